// File: doc/BRIEF.md
# Operand Dependency Hazard Checker

This block decides, within the same cycle, whether the instruction now being issued needs the result of the instruction issued one cycle earlier. Each operand is described by a three-bit kind code and a register index. The block compares the earlier instruction's destination descriptor with both source descriptors of the current instruction. It raises a single `hazard` output when either source depends on that destination.

Whether a dependency exists depends on the addressing modes of both operands, not only on the register numbers. Immediates and absolute addresses never depend on anything. A memory destination followed by a memory source is always a hazard, whatever the base registers are, so that a store completes before a later load. A dedicated flag resource carries the link from compare instructions to conditional branches.

The block is purely combinational. A stall or forwarding stage would use its output. It does not access the register file.

Top module: `hazardCheck`

## Requirements
- R1: Kind codes are 0 absent, 1 immediate, 2 half-word immediate, 3 register direct, 4 memory at base register plus displacement, 5 absolute address, 6 flag resource and 7 reserved. If the destination or the source has kind 0, that pair reports no dependency.
- R2: A source of kind 1 or 2 never depends on the destination.
- R3: A register-direct source (3) depends on a register-direct destination (3) exactly when the two indices are equal.
- R4: A register-direct source (3) never depends on a memory destination (4).
- R5: A memory source (4) depends on a register-direct destination (3) exactly when the destination index equals the source's base index.
- R6: A memory source (4) always depends on a memory destination (4), whatever the two indices are.
- R7: An absolute-address operand (5), used as either the source or the destination, never produces a dependency.
- R8: A flag source (6) depends on a flag destination (6) regardless of the indices. A flag operand paired with any other kind produces no dependency.
- R9: `hazard` is the OR of the checks of source A and source B against the destination. It follows the inputs in the same cycle, with no register on the path.
- R10: A destination of kind 1, 2 or 7, or a source of kind 7, never produces a dependency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| prevDstKind | input | 3 | Kind code of the previous instruction's destination |
| prevDstIdx | input | IDX_W | Register index of that destination |
| srcAKind | input | 3 | Kind code of the current first source |
| srcAIdx | input | IDX_W | Register or base index of the first source |
| srcBKind | input | 3 | Kind code of the current second source |
| srcBIdx | input | IDX_W | Register or base index of the second source |
| hazard | output | 1 | High when either source depends on the destination |

## Verification
Immediate assertions watch every input change. They check four things: an absent, absolute or non-writable destination never raises `hazard`; a memory-to-memory pair always raises it; an immediate source never arms a comparison or a forced hit; and the control strobes never request an index compare and a forced hit together. Whether the index comparison is made only for the mode pairs that call for it, including equal versus unequal indices, can only be shown by the bench's exhaustive sweep of all mode pairs on each source slot. The same holds for the OR of the two slots, which the bench checks with random two-source vectors.

// File: rtl/hazPkg.sv
package hazPkg;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    KIND_NONE    = 3'd0,
    KIND_IMM     = 3'd1,
    KIND_IMMHALF = 3'd2,
    KIND_REG     = 3'd3,
    KIND_MEM     = 3'd4,
    KIND_ABS     = 3'd5,
    KIND_FLAG    = 3'd6,
    KIND_RSVD    = 3'd7
  } opKind_e;

  // Per-source decision handed from control to datapath
  typedef struct packed {
    logic cmpIdx;    // hit only if indices match
    logic forceHit;  // hit whatever the indices are
  } pairStrobe_t;
endpackage

// File: rtl/hazCtrl.sv
module hazCtrl
  import hazPkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic [KIND_W-1:0]               dstKind,
  input  logic [NUM_SRC-1:0][KIND_W-1:0]  srcKind,
  output pairStrobe_t [NUM_SRC-1:0]       strobes
);
  logic dstIsReg, dstIsMem, dstIsFlag;

  always_comb begin
    dstIsReg  = (dstKind == KIND_REG);
    dstIsMem  = (dstKind == KIND_MEM);
    dstIsFlag = (dstKind == KIND_FLAG);
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    logic srcIsReg, srcIsMem, srcIsFlag, srcIsImm;

    always_comb begin
      srcIsReg  = (srcKind[g] == KIND_REG);
      srcIsMem  = (srcKind[g] == KIND_MEM);
      srcIsFlag = (srcKind[g] == KIND_FLAG);
      srcIsImm  = (srcKind[g] == KIND_IMM) || (srcKind[g] == KIND_IMMHALF);
      // register-direct destination: compared against source register or base
      strobes[g].cmpIdx   = dstIsReg && (srcIsReg || srcIsMem);
      // memory after memory, flag after flag: unconditional
      strobes[g].forceHit = (dstIsMem && srcIsMem) || (dstIsFlag && srcIsFlag);
    end

    always_comb begin
      AST_IMM_SRC_QUIET: assert (!srcIsImm || (!strobes[g].cmpIdx && !strobes[g].forceHit)); // R2
      AST_STROBE_EXCL: assert (!(strobes[g].cmpIdx && strobes[g].forceHit)); // R8
    end
  end
endmodule

// File: rtl/hazDatapath.sv
module hazDatapath
  import hazPkg::*;
#(
  parameter int NUM_SRC = 2,
  parameter int IDX_W   = 5
) (
  input  logic [IDX_W-1:0]               dstIdx,
  input  logic [NUM_SRC-1:0][IDX_W-1:0]  srcIdx,
  input  pairStrobe_t [NUM_SRC-1:0]      strobes,
  output logic                           hazard
);
  logic [NUM_SRC-1:0] srcHit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gCmp
    logic idxEq;
    always_comb begin
      idxEq     = (srcIdx[g] == dstIdx);
      srcHit[g] = strobes[g].forceHit || (strobes[g].cmpIdx && idxEq);
    end
  end

  always_comb hazard = |srcHit;
endmodule

// File: rtl/hazardCheck.sv
module hazardCheck
  import hazPkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [KIND_W-1:0] prevDstKind,
  input  logic [IDX_W-1:0]  prevDstIdx,
  input  logic [KIND_W-1:0] srcAKind,
  input  logic [IDX_W-1:0]  srcAIdx,
  input  logic [KIND_W-1:0] srcBKind,
  input  logic [IDX_W-1:0]  srcBIdx,
  output logic              hazard
);
  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][KIND_W-1:0] srcKindVec;
  logic [NUM_SRC-1:0][IDX_W-1:0]  srcIdxVec;
  pairStrobe_t [NUM_SRC-1:0]      strobeVec;

  always_comb begin
    srcKindVec[0] = srcAKind;
    srcKindVec[1] = srcBKind;
    srcIdxVec[0]  = srcAIdx;
    srcIdxVec[1]  = srcBIdx;
  end

  hazCtrl #(.NUM_SRC(NUM_SRC)) ctrl_i (
    .dstKind (prevDstKind),
    .srcKind (srcKindVec),
    .strobes (strobeVec)
  );

  hazDatapath #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) dp_i (
    .dstIdx  (prevDstIdx),
    .srcIdx  (srcIdxVec),
    .strobes (strobeVec),
    .hazard  (hazard)
  );

  always_comb begin
    AST_ABSENT_DST_QUIET: assert (prevDstKind != KIND_NONE || !hazard); // R1
    AST_ABS_DST_QUIET: assert (prevDstKind != KIND_ABS || !hazard); // R7
    AST_MEM_MEM_HIT: assert (!(prevDstKind == KIND_MEM &&
                              (srcAKind == KIND_MEM || srcBKind == KIND_MEM)) || hazard); // R6
    AST_NONWRITE_DST_QUIET: assert (!(prevDstKind == KIND_IMM || prevDstKind == KIND_IMMHALF ||
                                     prevDstKind == KIND_RSVD) || !hazard); // R10
  end
endmodule

// File: tb/hazardCheck_tb_top.sv
module hazardCheck_tb_top;
  localparam int IDX_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [2:0]       dK, aK, bK;
  logic [IDX_W-1:0] dI, aI, bI;
  logic             hazard;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  hazardCheck #(.IDX_W(IDX_W)) dut_i (
    .prevDstKind (dK), .prevDstIdx (dI),
    .srcAKind    (aK), .srcAIdx    (aI),
    .srcBKind    (bK), .srcBIdx    (bI),
    .hazard      (hazard)
  );

  function automatic bit refPair(input logic [2:0] dk, input logic [IDX_W-1:0] di,
                                 input logic [2:0] sk, input logic [IDX_W-1:0] si);
    case (sk)
      3'd3:    return (dk == 3'd3) && (di == si);
      3'd4:    return (dk == 3'd4) || ((dk == 3'd3) && (di == si));
      3'd6:    return dk == 3'd6;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tagOf(input logic [2:0] dk, input logic [2:0] sk);
    if (dk == 3'd0 || sk == 3'd0) return "R1";
    if (sk == 3'd1 || sk == 3'd2) return "R2";
    if (dk == 3'd5 || sk == 3'd5) return "R7";
    if (dk == 3'd7 || sk == 3'd7 || dk == 3'd1 || dk == 3'd2) return "R10";
    if (dk == 3'd6 || sk == 3'd6) return "R8";
    if (sk == 3'd3 && dk == 3'd3) return "R3";
    if (sk == 3'd3) return "R4";
    if (dk == 3'd3) return "R5";
    return "R6";
  endfunction

  task automatic applyCheck(input string tag, input bit expVal);
    #2;
    nChecks++;
    if (hazard !== expVal) begin
      nFails++;
      $display("FAIL %s: dst=%0d/%0d a=%0d/%0d b=%0d/%0d hazard=%0b expected=%0b",
               tag, dK, dI, aK, aI, bK, bI, hazard, expVal);
    end
    @(negedge clk);
  endtask

  initial begin
    dK = 3'd0; dI = '0; aK = 3'd0; aI = '0; bK = 3'd0; bI = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    applyCheck("R1", 1'b0);  // idle inputs: all absent

    // Exhaustive mode-pair sweep, equal and unequal indices, on each slot
    for (int slot = 0; slot < 2; slot++) begin
      for (int dk = 0; dk < 8; dk++) begin
        for (int sk = 0; sk < 8; sk++) begin
          for (int eq = 0; eq < 2; eq++) begin
            dK = 3'(dk);
            dI = 5'(7 + dk);
            if (slot == 0) begin
              aK = 3'(sk); aI = eq ? dI : dI ^ 5'h11; bK = 3'd0; bI = dI;
            end else begin
              bK = 3'(sk); bI = eq ? dI : dI + 5'd1; aK = 3'd1; aI = dI;
            end
            applyCheck(tagOf(3'(dk), 3'(sk)),
                       refPair(3'(dk), dI, 3'(sk), eq ? dI : (slot == 0 ? dI ^ 5'h11 : dI + 5'd1)));
          end
        end
      end
    end

    // Directed: memory-memory with very different bases (R6)
    dK = 3'd4; dI = 5'd0; aK = 3'd4; aI = 5'd31; bK = 3'd0; bI = '0;
    applyCheck("R6", 1'b1);
    // Directed: flag pair with differing indices (R8)
    dK = 3'd6; dI = 5'd2; aK = 3'd3; aI = 5'd2; bK = 3'd6; bI = 5'd9;
    applyCheck("R8", 1'b1);
    // Directed: both slots hit at once (R9)
    dK = 3'd3; dI = 5'd12; aK = 3'd3; aI = 5'd12; bK = 3'd4; bI = 5'd12;
    applyCheck("R9", 1'b1);

    // Random two-source vectors, combined OR (R9)
    void'($urandom(32'd20240607));
    for (int n = 0; n < 3000; n++) begin
      dK = 3'($urandom_range(0, 7));
      aK = 3'($urandom_range(0, 7));
      bK = 3'($urandom_range(0, 7));
      dI = 5'($urandom_range(0, 3));
      aI = 5'($urandom_range(0, 3));
      bI = 5'($urandom_range(0, 3));
      applyCheck("R9", refPair(dK, dI, aK, aI) | refPair(dK, dI, bK, bI));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule